// File: doc/BRIEF.md
# Unified TLB Lookup and Protection Unit

This block translates a 32-bit virtual data address through a fully associative unified translation buffer. Every entry carries a virtual page number, an address-space identifier, a physical page number, a two-bit page-size code, valid and shared flags, two protection bits and a dirty flag. On each request the unit resolves the access and returns a registered result one cycle later. That result holds a physical address, a success flag and a 12-bit exception code.

Addresses in the privileged direct-mapped windows bypass the buffer, and so does every address when translation is disabled. User-mode accesses to the upper half of the space raise an address error, except in a small window. Translated accesses search all entries in parallel. The search reports a miss, a multiple hit, a protection violation or a first write to a clean page. A replacement counter advances on every search of the buffer and wraps at a programmable boundary. Software loads write the entry that the counter currently points at. The page number of the last faulting access is kept for the miss handler.

The control flow is a two-state machine. `ST_IDLE` means no result is presented. `ST_RESP` means a result is presented. The transition `ST_IDLE -> ST_RESP` fires on a request. `ST_RESP -> ST_RESP` fires on a back-to-back request. `ST_RESP -> ST_IDLE` fires when no request follows. `ST_IDLE -> ST_IDLE` holds while no request arrives.

Top module: `utlb_xlate`

## Requirements
- R1: `rsp_valid_o` is high exactly in the cycle after a cycle with `req_i` high. The result fields are registered at that same edge.
- R2: In privileged mode, addresses 0x80000000..0xBFFFFFFF succeed with PA = VA & 0x1FFFFFFF. Addresses 0xE0000000 and above succeed with PA = VA. Neither case searches the buffer.
- R3: In user mode (`md_i`=0), any address at or above 0x80000000 gives exception 0x0E0 for a read and 0x100 for a write. The exception is the window 0xE0000000..0xE3FFFFFF, which succeeds with PA = VA.
- R4: When `at_i`=0, every remaining address (below 0x80000000, or 0xC0000000..0xDFFFFFFF in privileged mode) succeeds with PA = VA & 0x1FFFFFFF and does not search.
- R5: The size code selects the page: 0 = 1 KB, 1 = 4 KB, 2 = 64 KB, 3 = 1 MB. The VPN (VA bits 31:10) is compared only above the page offset. PA = ((PPN<<10) with the offset bits cleared) | (VA offset bits), with PA bits 31:29 zero.
- R6: The ASID is compared only when `sv_i`=0 or `md_i`=0. An entry with its shared flag set matches any ASID.
- R7: An entry with valid=0 never matches. A search with no match gives 0x040 for a read and 0x060 for a write.
- R8: A search matching two or more entries gives exception 0x140.
- R9: On a single match in user mode with protection bit 1 clear, the result is 0x0A0 for a read and 0x0C0 for a write.
- R10: Otherwise, a write with protection bit 0 clear gives 0x0C0. A write to an entry with dirty=0 gives 0x080. Any other single match succeeds, and `rsp_hit_o`=1 exactly when the code is 0x000.
- R11: Every faulting result except 0x140 loads VA bits 31:10 into `fault_vpn_o`. A result of 0x140 or a success leaves it unchanged.
- R12: The counter `urc_o` advances by one on every request that searches the buffer. It becomes 0 instead when the incremented value exceeds a nonzero `urb_i`, or exceeds ENTRIES-1. Requests that do not search leave it unchanged.
- R13: A load (`ld_i`=1) writes its fields into the entry indexed by `urc_o` and does not change `urc_o`.
- R14: After reset, all entries are invalid, `urc_o`=0, `fault_vpn_o`=0 and `rsp_valid_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Lookup request strobe |
| vaddr_i | input | 32 | Virtual address |
| wr_i | input | 1 | 1 = write, 0 = read |
| md_i | input | 1 | 1 = privileged mode |
| at_i | input | 1 | Translation enable |
| sv_i | input | 1 | Single-space mode (skip ASID in privileged mode) |
| urb_i | input | IW | Replacement wrap boundary (0 = none) |
| asid_i | input | 8 | Current address-space identifier |
| ld_i | input | 1 | Load entry at replacement counter |
| ld_vpn_i | input | 22 | Load: virtual page number |
| ld_asid_i | input | 8 | Load: ASID |
| ld_ppn_i | input | 19 | Load: physical page number |
| ld_sz_i | input | 2 | Load: size code |
| ld_v_i | input | 1 | Load: valid |
| ld_sh_i | input | 1 | Load: shared |
| ld_pr_i | input | 2 | Load: protection bits |
| ld_d_i | input | 1 | Load: dirty |
| rsp_valid_o | output | 1 | Result valid |
| rsp_hit_o | output | 1 | Access succeeded |
| rsp_exc_o | output | 12 | Exception code (0 = none) |
| rsp_pa_o | output | 32 | Physical address |
| fault_vpn_o | output | 22 | Last faulting page number |
| urc_o | output | IW | Replacement counter |

## Verification
The bench builds the unit with ENTRIES=8, so IW=3. A handful of searches then drives the counter through both wrap paths, the programmed boundary and the top of the array. Loads also cycle around and evict earlier entries, which exercises overlaps and multiple hits without extra setup. The small array lets the bench keep a full arithmetic model of every entry. It sweeps all sixteen address nibbles against mode, direction and enable, every size code at its page edges, and every protection and dirty combination.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

    localparam int VA_W   = 32;
    localparam int VPN_W  = 22;
    localparam int PPN_W  = 19;
    localparam int ASID_W = 8;
    localparam int EXC_W  = 12;

    localparam logic [EXC_W-1:0] EXC_NONE    = 12'h000;
    localparam logic [EXC_W-1:0] EXC_RD_MISS = 12'h040;
    localparam logic [EXC_W-1:0] EXC_WR_MISS = 12'h060;
    localparam logic [EXC_W-1:0] EXC_INIT_WR = 12'h080;
    localparam logic [EXC_W-1:0] EXC_RD_PROT = 12'h0A0;
    localparam logic [EXC_W-1:0] EXC_WR_PROT = 12'h0C0;
    localparam logic [EXC_W-1:0] EXC_RD_ADDR = 12'h0E0;
    localparam logic [EXC_W-1:0] EXC_WR_ADDR = 12'h100;
    localparam logic [EXC_W-1:0] EXC_MULTI   = 12'h140;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PPN_W-1:0]  ppn;
        logic [1:0]        sz;
        logic              valid;
        logic              shared;
        logic [1:0]        prot;
        logic              dirty;
    } tlb_entry_t;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } state_t;

    // Mask over the 1 KB-granular page number: ones where bits take part in the compare.
    function automatic logic [VPN_W-1:0] size_mask(input logic [1:0] sz);
        logic [VPN_W-1:0] m;
        unique case (sz)
            2'd0: m = {VPN_W{1'b1}};
            2'd1: m = {{(VPN_W-2){1'b1}}, 2'b0};
            2'd2: m = {{(VPN_W-6){1'b1}}, 6'b0};
            default: m = {{(VPN_W-10){1'b1}}, 10'b0};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/utlb_entry_array.sv
module utlb_entry_array
    import utlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  tlb_entry_t        wr_entry,
    input  logic [VPN_W-1:0]  look_vpn,
    input  logic [ASID_W-1:0] look_asid,
    input  logic              use_asid,
    output logic              one_hit,
    output logic              multi_hit,
    output tlb_entry_t        hit_entry
);

    tlb_entry_t       mem [ENTRIES];
    logic [ENTRIES-1:0] match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= wr_entry;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic asid_ok;
        logic page_ok;
        assign asid_ok  = mem[g].shared || !use_asid || (mem[g].asid == look_asid);
        assign page_ok  = ((look_vpn ^ mem[g].vpn) & size_mask(mem[g].sz)) == '0;
        assign match[g] = mem[g].valid && asid_ok && page_ok;
    end

    always_comb begin
        logic seen;
        seen      = 1'b0;
        multi_hit = 1'b0;
        hit_entry = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                if (seen) begin
                    multi_hit = 1'b1;
                end
                seen      = 1'b1;
                hit_entry = hit_entry | mem[i];
            end
        end
        one_hit = seen && !multi_hit;
    end

endmodule

// File: rtl/utlb_classify.sv
module utlb_classify
    import utlb_pkg::*;
(
    input  logic             [VA_W-1:0] vaddr,
    input  logic                        wr,
    input  logic                        md,
    input  logic                        at,
    input  logic                        one_hit,
    input  logic                        multi_hit,
    input  tlb_entry_t                  hit_entry,
    output logic                        search,
    output logic                        ok,
    output logic             [EXC_W-1:0] exc,
    output logic             [VA_W-1:0] pa
);

    logic             in_direct;
    logic             in_ctrl;
    logic             user_win;
    logic [VPN_W-1:0] msk;
    logic [PPN_W-1:0] ppn_merged;

    assign in_direct  = (vaddr[31:30] == 2'b10);
    assign in_ctrl    = (vaddr[31:29] == 3'b111);
    assign user_win   = (vaddr[31:26] == 6'b111000);
    assign msk        = size_mask(hit_entry.sz);
    assign ppn_merged = (hit_entry.ppn & msk[PPN_W-1:0]) | (vaddr[28:10] & ~msk[PPN_W-1:0]);

    always_comb begin
        search = 1'b0;
        exc    = EXC_NONE;
        pa     = '0;
        if (!md && vaddr[31] && !user_win) begin
            exc = wr ? EXC_WR_ADDR : EXC_RD_ADDR;
        end else if (in_direct) begin
            pa = {3'b000, vaddr[28:0]};
        end else if (in_ctrl) begin
            pa = vaddr;
        end else if (!at) begin
            pa = {3'b000, vaddr[28:0]};
        end else begin
            search = 1'b1;
            if (multi_hit) begin
                exc = EXC_MULTI;
            end else if (!one_hit) begin
                exc = wr ? EXC_WR_MISS : EXC_RD_MISS;
            end else if (!md && !hit_entry.prot[1]) begin
                exc = wr ? EXC_WR_PROT : EXC_RD_PROT;
            end else if (wr && !hit_entry.prot[0]) begin
                exc = EXC_WR_PROT;
            end else if (wr && !hit_entry.dirty) begin
                exc = EXC_INIT_WR;
            end else begin
                pa = {3'b000, ppn_merged, vaddr[9:0]};
            end
        end
        ok = (exc == EXC_NONE);
    end

endmodule

// File: rtl/utlb_urc.sv
module utlb_urc #(
    parameter int ENTRIES = 64,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [IW-1:0] urb,
    output logic [IW-1:0] urc
);

    localparam logic [IW:0] TOP = IW'(ENTRIES - 1);

    logic [IW:0] inc;
    logic        wrap;

    assign inc  = {1'b0, urc} + 1'b1;
    assign wrap = ((urb != '0) && (inc > {1'b0, urb})) || (inc > TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            urc <= '0;
        end else if (step) begin
            urc <= wrap ? '0 : inc[IW-1:0];
        end
    end

endmodule

// File: rtl/utlb_xlate.sv
module utlb_xlate
    import utlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [31:0]       vaddr_i,
    input  logic              wr_i,
    input  logic              md_i,
    input  logic              at_i,
    input  logic              sv_i,
    input  logic [IW-1:0]     urb_i,
    input  logic [7:0]        asid_i,
    input  logic              ld_i,
    input  logic [21:0]       ld_vpn_i,
    input  logic [7:0]        ld_asid_i,
    input  logic [18:0]       ld_ppn_i,
    input  logic [1:0]        ld_sz_i,
    input  logic              ld_v_i,
    input  logic              ld_sh_i,
    input  logic [1:0]        ld_pr_i,
    input  logic              ld_d_i,
    output logic              rsp_valid_o,
    output logic              rsp_hit_o,
    output logic [11:0]       rsp_exc_o,
    output logic [31:0]       rsp_pa_o,
    output logic [21:0]       fault_vpn_o,
    output logic [IW-1:0]     urc_o
);

    state_t           state;
    state_t           state_nxt;
    tlb_entry_t       ld_entry;
    tlb_entry_t       hit_entry;
    logic             one_hit;
    logic             multi_hit;
    logic             search_w;
    logic             ok_w;
    logic [EXC_W-1:0] exc_w;
    logic [VA_W-1:0]  pa_w;
    logic             use_asid;

    assign use_asid = !sv_i || !md_i;
    assign ld_entry = '{vpn: ld_vpn_i, asid: ld_asid_i, ppn: ld_ppn_i, sz: ld_sz_i,
                        valid: ld_v_i, shared: ld_sh_i, prot: ld_pr_i, dirty: ld_d_i};

    utlb_entry_array #(.ENTRIES(ENTRIES)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ld_i),
        .wr_idx    (urc_o),
        .wr_entry  (ld_entry),
        .look_vpn  (vaddr_i[31:10]),
        .look_asid (asid_i),
        .use_asid  (use_asid),
        .one_hit   (one_hit),
        .multi_hit (multi_hit),
        .hit_entry (hit_entry)
    );

    utlb_classify u_classify (
        .vaddr     (vaddr_i),
        .wr        (wr_i),
        .md        (md_i),
        .at        (at_i),
        .one_hit   (one_hit),
        .multi_hit (multi_hit),
        .hit_entry (hit_entry),
        .search    (search_w),
        .ok        (ok_w),
        .exc       (exc_w),
        .pa        (pa_w)
    );

    utlb_urc #(.ENTRIES(ENTRIES)) u_urc (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (req_i && search_w),
        .urb   (urb_i),
        .urc   (urc_o)
    );

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: state_nxt = req_i ? ST_RESP : ST_IDLE;
            ST_RESP: state_nxt = req_i ? ST_RESP : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_hit_o   <= 1'b0;
            rsp_exc_o   <= EXC_NONE;
            rsp_pa_o    <= '0;
            fault_vpn_o <= '0;
        end else if (req_i) begin
            rsp_hit_o <= ok_w;
            rsp_exc_o <= exc_w;
            rsp_pa_o  <= pa_w;
            if (!ok_w && (exc_w != EXC_MULTI)) begin
                fault_vpn_o <= vaddr_i[31:10];
            end
        end
    end

    assign rsp_valid_o = (state == ST_RESP);

endmodule

// File: rtl/utlb_xlate_chk.sv
module utlb_xlate_chk #(
    parameter int IW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req,
    input logic [31:0]   vaddr,
    input logic          wr,
    input logic          md,
    input logic          search,
    input logic [IW-1:0] urb,
    input logic [IW-1:0] urc,
    input logic          rsp_valid,
    input logic          rsp_hit,
    input logic [11:0]   rsp_exc,
    input logic [31:0]   rsp_pa,
    input logic [21:0]   fault_vpn
);

    // R1
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rsp_valid);

    // R1
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !rsp_valid);

    // R2
    direct_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && md && vaddr[31:30] == 2'b10) |=> (rsp_hit && rsp_pa == {3'b000, $past(vaddr[28:0])}));

    // R3
    user_addr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !md && vaddr[31] && vaddr[31:26] != 6'b111000)
        |=> (rsp_exc == ($past(wr) ? 12'h100 : 12'h0E0)));

    // R11
    multi_keeps_vpn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_exc == 12'h140) |-> $stable(fault_vpn));

    // R12
    urc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && search && urb != '0 && urc >= urb) |=> (urc == '0));

    // R12
    urc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && search) |=> $stable(urc));

endmodule

bind utlb_xlate utlb_xlate_chk #(.IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req_i),
    .vaddr     (vaddr_i),
    .wr        (wr_i),
    .md        (md_i),
    .search    (search_w),
    .urb       (urb_i),
    .urc       (urc_o),
    .rsp_valid (rsp_valid_o),
    .rsp_hit   (rsp_hit_o),
    .rsp_exc   (rsp_exc_o),
    .rsp_pa    (rsp_pa_o),
    .fault_vpn (fault_vpn_o)
);

// File: tb/utlb_xlate_tb.sv
module utlb_xlate_tb;

    localparam int N  = 8;
    localparam int IW = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [31:0] vaddr = '0;
    logic        wr = 1'b0, md = 1'b1, at = 1'b1, sv = 1'b0;
    logic [IW-1:0] urb = '0;
    logic [7:0]  asid = '0;
    logic        ld = 1'b0;
    logic [21:0] ld_vpn = '0;
    logic [7:0]  ld_asid = '0;
    logic [18:0] ld_ppn = '0;
    logic [1:0]  ld_sz = '0, ld_pr = '0;
    logic        ld_v = 1'b0, ld_sh = 1'b0, ld_d = 1'b0;
    logic        rsp_valid_o, rsp_hit_o;
    logic [11:0] rsp_exc_o;
    logic [31:0] rsp_pa_o;
    logic [21:0] fault_vpn_o;
    logic [IW-1:0] urc_o;

    int checks = 0;
    int failures = 0;

    logic [21:0] m_vpn [N];
    logic [7:0]  m_asid [N];
    logic [18:0] m_ppn [N];
    logic [1:0]  m_sz [N], m_pr [N];
    logic        m_v [N], m_sh [N], m_d [N];
    logic [IW-1:0] m_urc = '0;
    logic [21:0] m_fault = '0;

    always #2.5 clk = ~clk;

    utlb_xlate #(.ENTRIES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .vaddr_i(vaddr), .wr_i(wr), .md_i(md),
        .at_i(at), .sv_i(sv), .urb_i(urb), .asid_i(asid), .ld_i(ld), .ld_vpn_i(ld_vpn),
        .ld_asid_i(ld_asid), .ld_ppn_i(ld_ppn), .ld_sz_i(ld_sz), .ld_v_i(ld_v),
        .ld_sh_i(ld_sh), .ld_pr_i(ld_pr), .ld_d_i(ld_d), .rsp_valid_o(rsp_valid_o),
        .rsp_hit_o(rsp_hit_o), .rsp_exc_o(rsp_exc_o), .rsp_pa_o(rsp_pa_o),
        .fault_vpn_o(fault_vpn_o), .urc_o(urc_o)
    );

    task automatic chk(input logic ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] sz_bytes(input logic [1:0] s);
        case (s)
            2'd0: return 32'h400;
            2'd1: return 32'h1000;
            2'd2: return 32'h10000;
            default: return 32'h100000;
        endcase
    endfunction

    function automatic logic [IW-1:0] urc_next(input logic [IW-1:0] u);
        int n = int'(u) + 1;
        if ((urb != 0 && n > int'(urb)) || n > N - 1) return '0;
        return IW'(n);
    endfunction

    function automatic void model(input logic [31:0] a, input logic w, m, t, s, input logic [7:0] as,
                                  output logic h, output logic [11:0] e, output logic [31:0] p,
                                  output logic srch);
        int cnt = 0;
        int sel = 0;
        h = 1'b0; e = 12'h000; p = '0; srch = 1'b0;
        if (!m && a >= 32'h8000_0000 && !(a >= 32'hE000_0000 && a < 32'hE400_0000)) begin
            e = w ? 12'h100 : 12'h0E0;
        end else if (a >= 32'h8000_0000 && a < 32'hC000_0000) begin
            h = 1'b1; p = a & 32'h1FFF_FFFF;
        end else if (a >= 32'hE000_0000) begin
            h = 1'b1; p = a;
        end else if (!t) begin
            h = 1'b1; p = a & 32'h1FFF_FFFF;
        end else begin
            srch = 1'b1;
            for (int i = 0; i < N; i++) begin
                logic [31:0] sz = sz_bytes(m_sz[i]);
                logic [31:0] st = {m_vpn[i], 10'b0} & ~(sz - 1);
                if (m_v[i] && (m_sh[i] || (s && m) || m_asid[i] == as) &&
                    a >= st && a <= st + sz - 1) begin
                    cnt++; sel = i;
                end
            end
            if (cnt > 1) e = 12'h140;
            else if (cnt == 0) e = w ? 12'h060 : 12'h040;
            else if (!m && !m_pr[sel][1]) e = w ? 12'h0C0 : 12'h0A0;
            else if (w && !m_pr[sel][0]) e = 12'h0C0;
            else if (w && !m_d[sel]) e = 12'h080;
            else begin
                logic [31:0] sz = sz_bytes(m_sz[sel]);
                h = 1'b1;
                p = ({3'b000, m_ppn[sel], 10'b0} & ~(sz - 1)) | (a & (sz - 1));
            end
        end
    endfunction

    task automatic do_load(input logic [21:0] vp, input logic [7:0] as, input logic [18:0] pp,
                           input logic [1:0] s, input logic v, sh, input logic [1:0] pr, input logic d);
        @(negedge clk);
        ld = 1'b1; ld_vpn = vp; ld_asid = as; ld_ppn = pp; ld_sz = s; ld_v = v; ld_sh = sh;
        ld_pr = pr; ld_d = d;
        m_vpn[m_urc] = vp; m_asid[m_urc] = as; m_ppn[m_urc] = pp; m_sz[m_urc] = s;
        m_v[m_urc] = v; m_sh[m_urc] = sh; m_pr[m_urc] = pr; m_d[m_urc] = d;
        @(negedge clk);
        ld = 1'b0;
        // R13: a load leaves the counter where it was
        chk(urc_o == m_urc, "R13", 32'(urc_o), 32'(m_urc));
    endtask

    task automatic do_req(input logic [31:0] a, input logic w, m, t, s, input logic [7:0] as,
                          input string tag);
        logic eh, es;
        logic [11:0] ee;
        logic [31:0] ep;
        @(negedge clk);
        chk(rsp_valid_o == 1'b0, "R1", 32'(rsp_valid_o), 0);
        vaddr = a; wr = w; md = m; at = t; sv = s; asid = as; req = 1'b1;
        model(a, w, m, t, s, as, eh, ee, ep, es);
        @(negedge clk);
        req = 1'b0;
        chk(rsp_valid_o == 1'b1, "R1", 32'(rsp_valid_o), 1);
        chk(rsp_exc_o == ee, tag, 32'(rsp_exc_o), 32'(ee));
        chk(rsp_hit_o == eh, tag, 32'(rsp_hit_o), 32'(eh));
        if (eh) chk(rsp_pa_o == ep, tag, rsp_pa_o, ep);
        if (ee != 12'h000 && ee != 12'h140) m_fault = a[31:10];
        if (es) m_urc = urc_next(m_urc);
        chk(fault_vpn_o == m_fault, "R11", 32'(fault_vpn_o), 32'(m_fault));
        chk(urc_o == m_urc, "R12", 32'(urc_o), 32'(m_urc));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_vpn[i] = '0; m_asid[i] = '0; m_ppn[i] = '0; m_sz[i] = '0;
            m_v[i] = 1'b0; m_sh[i] = 1'b0; m_pr[i] = '0; m_d[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R14: reset state
        chk(rsp_valid_o == 1'b0, "R14", 32'(rsp_valid_o), 0);
        chk(urc_o == '0, "R14", 32'(urc_o), 0);
        chk(fault_vpn_o == '0, "R14", 32'(fault_vpn_o), 0);
        do_req(32'h0000_1000, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, "R14");

        // R2 R3 R4: address windows against mode, direction and enable
        for (int top = 0; top < 16; top++) begin
            for (int c = 0; c < 8; c++) begin
                do_req({4'(top), 28'h234_5678}, c[0], c[1], c[2], 1'b0, 8'h01,
                       top >= 8 ? (c[1] ? "R2" : "R3") : "R4");
            end
        end
        do_req(32'hE3FF_FFFC, 1'b1, 1'b0, 1'b1, 1'b0, 8'h01, "R3");
        do_req(32'hE400_0000, 1'b0, 1'b0, 1'b1, 1'b0, 8'h01, "R3");
        do_req(32'hDFFF_FFFC, 1'b0, 1'b1, 1'b0, 1'b0, 8'h01, "R4");

        // R5: page sizes at their edges
        for (int s = 0; s < 4; s++) begin
            logic [31:0] base = 32'h1000_0000 * (s + 1);
            logic [31:0] sz = sz_bytes(2'(s));
            logic [31:0] st;
            logic [21:0] vp = base[31:10] | 22'h155;
            st = {vp, 10'b0} & ~(sz - 1);
            do_load(vp, 8'h00, 19'h5_5AAA, 2'(s), 1'b1, 1'b1, 2'b11, 1'b1);
            do_req(st, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, "R5");
            do_req(st + sz - 1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R5");
            do_req(st + sz, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, "R5");
            do_req(st - 1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, "R5");
            do_req(st + (sz >> 1) + 4, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R5");
        end

        // R6: ASID rules and shared entries
        do_load(22'h01_2340, 8'h33, 19'h0_1111, 2'd1, 1'b1, 1'b0, 2'b11, 1'b1);
        do_load(22'h01_5000, 8'h10, 19'h0_2222, 2'd0, 1'b1, 1'b1, 2'b11, 1'b1);
        for (int c = 0; c < 4; c++) begin
            do_req(32'h048D_0010, 1'b0, c[0], 1'b1, c[1], 8'h33, "R6");
            do_req(32'h048D_0010, 1'b0, c[0], 1'b1, c[1], 8'h34, "R6");
            do_req(32'h0540_0020, 1'b0, c[0], 1'b1, c[1], 8'h77, "R6");
        end

        // R7: an invalid entry never matches
        do_load(22'h02_0000, 8'h00, 19'h0_3333, 2'd0, 1'b0, 1'b1, 2'b11, 1'b1);
        do_req(32'h0800_0004, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, "R7");
        do_req(32'h0800_0004, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R7");

        // R8: overlapping entries
        do_load(22'h03_0000, 8'h00, 19'h0_4000, 2'd3, 1'b1, 1'b1, 2'b11, 1'b1);
        do_load(22'h03_0008, 8'h00, 19'h0_5000, 2'd1, 1'b1, 1'b1, 2'b11, 1'b1);
        do_req(32'h0C00_2000, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R8");
        do_req(32'h0C00_2010, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, "R8");
        do_req(32'h0C08_0000, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, "R8");

        // R9 R10: every protection and dirty combination
        for (int k = 0; k < 8; k++) begin
            logic [31:0] pg = 32'h3000_0000 + 32'(k) * 32'h400;
            do_load(pg[31:10], 8'h00, 19'h0_6000 + 19'(k), 2'd0, 1'b1, 1'b1, 2'(k), k[2]);
            for (int c = 0; c < 4; c++) begin
                do_req(pg + 32'h24, c[0], c[1], 1'b1, 1'b0, 8'h00, c[1] ? "R10" : "R9");
            end
        end

        // R12: counter wrap at a programmed boundary, then at the top
        urb = 3'd5;
        for (int i = 0; i < 9; i++) do_req(32'h0000_0400 * i, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, "R12");
        urb = 3'd0;
        for (int i = 0; i < 9; i++) do_req(32'h0000_0400 * i, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R12");

        // R13: load at the counter and find it
        do_load(22'h00_0ABC, 8'h00, 19'h0_7777, 2'd0, 1'b1, 1'b1, 2'b11, 1'b1);
        do_req(32'h002A_F008, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R13");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule